// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Cycle Controller

This block sits between a synchronous request/acknowledge port inside the chip and an external asynchronous static RAM. The RAM has a 19-bit address, an 8-bit data bus and three active-low strobes: chip select, write enable and output enable. The controller takes one read or one write at a time. It registers the address and the write data, then steps the strobes through a sequence whose phase lengths are whole clock cycles. Each phase length is derived from a nanosecond timing parameter and the clock period, rounded up, with a floor of one cycle. For a read it samples the RAM data on the last cycle of the access window and returns it with a one-cycle acknowledge.

Write cycles are controlled by write enable. Write enable and chip select fall on the same edge, and output enable stays high for the whole write. The controller keeps its data drivers off for a bus-release interval at the start of the write pulse, so that it never drives against data the RAM may still be putting out. Between accesses the RAM is left deselected so it can sit in standby. A retention request holds the RAM deselected and reports readiness for a supply drop. When the request is released, the controller waits one read cycle time before it accepts new work.

The data bus is split into input, output and output-enable ports, so the pad can be placed outside the block.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, chip select, write enable and output enable are high, the data output enable and both acknowledge and retention-ready are low, and `req_ready` is high while `ret_req` is low.
- R2: The strobe encoding is as follows. A read has chip select low, output enable low and write enable high. A write has chip select low, write enable low and output enable high. Whenever `req_ready` is high, chip select is high.
- R3: A read keeps chip select and output enable low for RD_CYC = ceil(max(access, read cycle)/period) cycles. It then presents the RAM byte at the registered address on `rsp_rdata`, together with `rsp_ack`.
- R4: Write enable falls on the same edge as chip select. Output enable is high throughout the write. The write pulse lasts WLOW_CYC cycles, the largest of ceil(pulse), ceil(select-to-end) and WZ_CYC+ceil(data setup). The acknowledge is given as the pulse ends.
- R5: During a write pulse, the controller's data driver is off for the first WZ_CYC = ceil(bus release) cycles. It is on for the remaining WLOW_CYC-WZ_CYC cycles, and it turns off on the edge where write enable rises.
- R6: The controller never drives the data bus while the RAM drives it, including the bus-release window after output enable rises.
- R7: `req_ready` drops on the edge that accepts a request. It returns ceil(bus release) cycles after a read's acknowledge edge, and ceil(write recovery) cycles after a write's.
- R8: Address and write data are captured on the accepting edge and stay stable for the whole access, whatever the request inputs do afterwards.
- R9: A retention request seen while idle keeps chip select high. It raises `ret_ready` ceil(deselect time) cycles later, and `req_ready` stays low throughout.
- R10: When a retention request and an access request arrive in the same idle cycle, the retention request wins. No access is started while retention is active.
- R11: After `ret_req` is released, `ret_ready` falls at once, and `req_ready` returns after ceil(read cycle time) cycles.
- R12: `rsp_ack` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle and able to accept |
| rsp_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with `rsp_ack` |
| ret_req | input | 1 | Enter and hold retention |
| ret_ready | output | 1 | RAM deselected long enough for a supply drop |
| sram_addr | output | 19 | RAM address |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_dq_out | output | 8 | Data toward RAM |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_out` |
| sram_dq_in | input | 8 | Data from RAM |

## Verification
The assertions assume that reset is held for at least two clocks, so that every `$past` and `$fell` term sees defined strobe values. They also assume that `ret_req` changes only at clock boundaries. The bench drives every input half a cycle away from the active edge and releases reset only after several cycles. It keeps a request asserted only until the edge that accepts it, and on that same edge it scrambles the address and data pins. This makes any late capture visible in the RAM model, which records the address, pulse length, data-setup length and bus contention in whole cycles.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WZ,
    ST_WD,
    ST_GAP,
    ST_RDESEL,
    ST_RHOLD,
    ST_RRECOV
  } ctrl_state_e;

  // whole cycles covering t_ns, never less than one
  function automatic int ns_to_cyc(input int t_ns, input int per_ns);
    int c;
    c = (t_ns + per_ns - 1) / per_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_access_fsm.sv
module sram_access_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 4,
  parameter int RD_CYC   = 7,
  parameter int WZ_CYC   = 4,
  parameter int WD_CYC   = 4,
  parameter int RGAP_CYC = 4,
  parameter int WGAP_CYC = 1,
  parameter int DESEL_CYC = 1,
  parameter int RECOV_CYC = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              ret_req,
  input  logic              tmr_zero,
  input  logic [DATA_W-1:0] dq_in,
  output logic              req_ready,
  output logic              accept,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic              cs_n,
  output logic              we_n,
  output logic              oe_n,
  output logic              dq_oe,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              ret_ready
);
  ctrl_state_e state_q, nxt;

  assign req_ready = (state_q == ST_IDLE) && !ret_req;
  assign accept    = req_ready && req_valid;

  always_comb begin
    nxt      = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: begin
        if (ret_req) begin
          nxt = ST_RDESEL; tmr_load = 1'b1; tmr_val = CNT_W'(DESEL_CYC - 1);
        end else if (req_valid) begin
          if (req_write) begin
            nxt = ST_WZ; tmr_load = 1'b1; tmr_val = CNT_W'(WZ_CYC - 1);
          end else begin
            nxt = ST_RD; tmr_load = 1'b1; tmr_val = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_RD: if (tmr_zero) begin
        nxt = ST_GAP; tmr_load = 1'b1; tmr_val = CNT_W'(RGAP_CYC - 1);
      end
      ST_WZ: if (tmr_zero) begin
        nxt = ST_WD; tmr_load = 1'b1; tmr_val = CNT_W'(WD_CYC - 1);
      end
      ST_WD: if (tmr_zero) begin
        nxt = ST_GAP; tmr_load = 1'b1; tmr_val = CNT_W'(WGAP_CYC - 1);
      end
      ST_GAP:    if (tmr_zero) nxt = ST_IDLE;
      ST_RDESEL: if (tmr_zero) nxt = ST_RHOLD;
      ST_RHOLD: if (!ret_req) begin
        nxt = ST_RRECOV; tmr_load = 1'b1; tmr_val = CNT_W'(RECOV_CYC - 1);
      end
      ST_RRECOV: if (tmr_zero) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  // strobes are registered, decoded from the state being entered
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cs_n      <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      dq_oe     <= 1'b0;
      ack       <= 1'b0;
      rdata     <= '0;
      ret_ready <= 1'b0;
    end else begin
      state_q   <= nxt;
      cs_n      <= !(nxt inside {ST_RD, ST_WZ, ST_WD});
      we_n      <= !(nxt inside {ST_WZ, ST_WD});
      oe_n      <= (nxt != ST_RD);
      dq_oe     <= (nxt == ST_WD);
      ack       <= (state_q inside {ST_RD, ST_WD}) && (nxt == ST_GAP);
      ret_ready <= (nxt == ST_RHOLD);
      if (state_q == ST_RD && nxt == ST_GAP) rdata <= dq_in;
    end
  end
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_ACCESS_NS   = 55,
  parameter int T_RCYCLE_NS   = 55,
  parameter int T_WPULSE_NS   = 45,
  parameter int T_WSEL_NS     = 50,
  parameter int T_DSETUP_NS   = 25,
  parameter int T_BUSREL_NS   = 30,
  parameter int T_WRECOV_NS   = 0,
  parameter int T_DESEL_NS    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              ret_req,
  output logic              ret_ready,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int RD_CYC    = ns_to_cyc(imax(T_ACCESS_NS, T_RCYCLE_NS), CLK_PERIOD_NS);
  localparam int WZ_CYC    = ns_to_cyc(T_BUSREL_NS, CLK_PERIOD_NS);
  localparam int WLOW_CYC  = imax(imax(ns_to_cyc(T_WPULSE_NS, CLK_PERIOD_NS),
                                       ns_to_cyc(T_WSEL_NS, CLK_PERIOD_NS)),
                                  WZ_CYC + ns_to_cyc(T_DSETUP_NS, CLK_PERIOD_NS));
  localparam int WD_CYC    = WLOW_CYC - WZ_CYC;
  localparam int RGAP_CYC  = ns_to_cyc(T_BUSREL_NS, CLK_PERIOD_NS);
  localparam int WGAP_CYC  = ns_to_cyc(T_WRECOV_NS, CLK_PERIOD_NS);
  localparam int DESEL_CYC = ns_to_cyc(T_DESEL_NS, CLK_PERIOD_NS);
  localparam int RECOV_CYC = ns_to_cyc(T_RCYCLE_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC   = imax(imax(imax(RD_CYC, WLOW_CYC), imax(RGAP_CYC, WGAP_CYC)),
                                  imax(DESEL_CYC, RECOV_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  logic              accept;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_zero;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram_access_fsm #(
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .RD_CYC    (RD_CYC),
    .WZ_CYC    (WZ_CYC),
    .WD_CYC    (WD_CYC),
    .RGAP_CYC  (RGAP_CYC),
    .WGAP_CYC  (WGAP_CYC),
    .DESEL_CYC (DESEL_CYC),
    .RECOV_CYC (RECOV_CYC)
  ) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .ret_req   (ret_req),
    .tmr_zero  (tmr_zero),
    .dq_in     (sram_dq_in),
    .req_ready (req_ready),
    .accept    (accept),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .cs_n      (sram_cs_n),
    .we_n      (sram_we_n),
    .oe_n      (sram_oe_n),
    .dq_oe     (sram_dq_oe),
    .ack       (rsp_ack),
    .rdata     (rsp_rdata),
    .ret_ready (ret_ready)
  );

  assign sram_addr   = addr_q;
  assign sram_dq_out = wdata_q;
endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_ack,
  input logic              ret_ready,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_cs_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_dq_oe
);
  assert_accept_selects_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!sram_cs_n && !req_ready));

  assert_ready_deselected_R2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> sram_cs_n);

  assert_write_oe_high_R4: assert property (@(posedge clk) disable iff (rst)
    (!sram_we_n) |-> sram_oe_n);

  assert_we_with_cs_R4: assert property (@(posedge clk) disable iff (rst)
    (!sram_cs_n && $fell(sram_we_n)) |-> $fell(sram_cs_n));

  assert_release_on_we_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> !sram_dq_oe);

  assert_drive_only_in_write_R6: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> (!sram_cs_n && !sram_we_n && sram_oe_n));

  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (!sram_cs_n && !$past(sram_cs_n)) |-> $stable(sram_addr));

  assert_retention_deselect_R9: assert property (@(posedge clk) disable iff (rst)
    ret_ready |-> (sram_cs_n && !req_ready));

  assert_ack_single_R12: assert property (@(posedge clk) disable iff (rst)
    rsp_ack |=> !rsp_ack);
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_ack    (rsp_ack),
  .ret_ready  (ret_ready),
  .sram_addr  (sram_addr),
  .sram_cs_n  (sram_cs_n),
  .sram_we_n  (sram_we_n),
  .sram_oe_n  (sram_oe_n),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_cycle_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_tb_top;
  localparam int P        = 8;
  localparam int TACC     = 55;
  localparam int TRC      = 55;
  localparam int TWP      = 45;
  localparam int TWSEL    = 50;
  localparam int TDS      = 25;
  localparam int TREL     = 30;
  localparam int TWR      = 0;
  localparam int TDESEL   = 0;

  function automatic int cyc(input int t);
    int c;
    c = (t + P - 1) / P;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD    = cyc(mx(TACC, TRC));
  localparam int E_WZ    = cyc(TREL);
  localparam int E_WLOW  = mx(mx(cyc(TWP), cyc(TWSEL)), E_WZ + cyc(TDS));
  localparam int E_WD    = E_WLOW - E_WZ;
  localparam int E_RGAP  = cyc(TREL);
  localparam int E_WGAP  = cyc(TWR);
  localparam int E_DESEL = cyc(TDESEL);
  localparam int E_RECOV = cyc(TRC);

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, ret_req;
  logic [18:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, rsp_ack, ret_ready;
  logic [7:0]  rsp_rdata;
  logic [18:0] sram_addr;
  logic        sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0]  sram_dq_out;
  logic [7:0]  sram_dq_in;

  always #4 clk = ~clk;

  sram_cycle_ctrl #(
    .CLK_PERIOD_NS(P), .T_ACCESS_NS(TACC), .T_RCYCLE_NS(TRC), .T_WPULSE_NS(TWP),
    .T_WSEL_NS(TWSEL), .T_DSETUP_NS(TDS), .T_BUSREL_NS(TREL), .T_WRECOV_NS(TWR),
    .T_DESEL_NS(TDESEL)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata), .ret_req(ret_req),
    .ret_ready(ret_ready), .sram_addr(sram_addr), .sram_cs_n(sram_cs_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  // ---------------- behavioural RAM model (cycle granularity) ----------------
  logic [7:0]  mem [logic [18:0]];
  int          rd_cnt, hold_cnt, conflicts, addr_errs;
  logic [18:0] rd_addr, w_addr;
  logic [7:0]  w_data, dq_in_r;
  int          w_len, w_pre, w_dat, w_ends;
  bit          w_oe_bad, wr_prev;

  function automatic logic [7:0] memval(input logic [18:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  assign sram_dq_in = dq_in_r;

  always @(negedge clk) begin
    bit rd_now, wr_now;
    if (rst) begin
      rd_cnt = 0; hold_cnt = 0; wr_prev = 0; dq_in_r = 8'h00;
    end else begin
      rd_now = !sram_cs_n && !sram_oe_n && sram_we_n;
      wr_now = !sram_cs_n && !sram_we_n;
      if (rd_now) begin
        rd_cnt++;
        if (rd_cnt == 1) rd_addr = sram_addr;
        else if (sram_addr != rd_addr) addr_errs++;
        hold_cnt = E_RGAP;
      end else begin
        rd_cnt = 0;
        if (hold_cnt > 0) hold_cnt--;
      end
      dq_in_r = (rd_now && rd_cnt * P >= TACC) ? memval(sram_addr) : ~memval(sram_addr);
      if (sram_dq_oe && (rd_now || hold_cnt > 0)) conflicts++;
      if (wr_now) begin
        if (!wr_prev) begin
          w_len = 0; w_pre = 0; w_dat = 0; w_oe_bad = 0; w_addr = sram_addr;
        end
        w_len++;
        if (sram_dq_oe) begin w_dat++; w_data = sram_dq_out; end
        else if (w_dat == 0) w_pre++;
        if (!sram_oe_n) w_oe_bad = 1;
        if (sram_addr != w_addr) addr_errs++;
      end else if (wr_prev) begin
        mem[w_addr] = w_data;
        w_ends++;
      end
      wr_prev = wr_now;
    end
  end

  // ---------------- checking ----------------
  int checks = 0, errors = 0;
  bit timed_out = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  function automatic logic [7:0] pat(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h5A;
  endfunction

  task automatic access(input bit wr, input logic [18:0] a, input logic [7:0] d,
                        output logic [7:0] rd);
    int k, g, ends0;
    while (!req_ready) tick();
    ends0 = w_ends;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    tick();
    if (wr)
      chk(!sram_cs_n && !sram_we_n && sram_oe_n, "R2", "write strobes", {sram_cs_n, sram_we_n, sram_oe_n}, 3'b001);
    else
      chk(!sram_cs_n && sram_we_n && !sram_oe_n, "R2", "read strobes", {sram_cs_n, sram_we_n, sram_oe_n}, 3'b010);
    chk(!req_ready, "R7", "busy after accept", req_ready, 0);
    req_valid = 0; req_addr = ~a; req_wdata = ~d;   // R8: pins scrambled
    k = 1;
    while (!rsp_ack) begin tick(); k++; end
    chk(k == (wr ? E_WLOW : E_RD) + 1, wr ? "R4" : "R3", "strobe window", k, (wr ? E_WLOW : E_RD) + 1);
    rd = rsp_rdata;
    tick();
    chk(!rsp_ack, "R12", "ack width", rsp_ack, 0);
    g = 0;
    while (!req_ready) begin g++; tick(); end
    chk(g == (wr ? E_WGAP : E_RGAP) - 1, "R7", "turnaround gap", g, (wr ? E_WGAP : E_RGAP) - 1);
    chk(sram_cs_n, "R2", "idle deselect", sram_cs_n, 1);
    if (wr) begin
      chk(w_ends == ends0 + 1, "R4", "one write pulse", w_ends - ends0, 1);
      chk(w_len == E_WLOW, "R4", "write pulse length", w_len, E_WLOW);
      chk(!w_oe_bad, "R4", "oe high in write", w_oe_bad, 0);
      chk(w_pre == E_WZ, "R5", "driver-off lead", w_pre, E_WZ);
      chk(w_dat == E_WD, "R5", "data setup cycles", w_dat, E_WD);
      chk(w_addr == a && w_data == d, "R8", "written addr/data", {w_addr, w_data}, {a, d});
    end
  endtask

  task automatic run_all();
    logic [7:0] r;
    int k;
    rst = 1; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; ret_req = 0;
    conflicts = 0; addr_errs = 0; w_ends = 0;
    repeat (5) tick();
    rst = 0;
    tick();
    // R1 reset state
    chk(sram_cs_n && sram_we_n && sram_oe_n, "R1", "strobes high", {sram_cs_n, sram_we_n, sram_oe_n}, 3'b111);
    chk(!sram_dq_oe && !rsp_ack && !ret_ready, "R1", "outputs low", {sram_dq_oe, rsp_ack, ret_ready}, 0);
    chk(req_ready, "R1", "ready", req_ready, 1);

    // walking-one address sweep plus the two extremes
    for (int i = 0; i <= 20; i++) begin
      logic [18:0] a;
      a = (i < 19) ? (19'd1 << i) : ((i == 19) ? 19'd0 : '1);
      access(1, a, pat(a), r);
    end
    for (int i = 0; i <= 20; i++) begin
      logic [18:0] a;
      a = (i < 19) ? (19'd1 << i) : ((i == 19) ? 19'd0 : '1);
      access(0, a, 8'h00, r);
      chk(r == pat(a), "R3", "read data", r, pat(a));
    end
    // overwrite, then back-to-back reads
    access(1, 19'h2A5A5, 8'h11, r);
    access(1, 19'h2A5A5, 8'hC3, r);
    access(0, 19'h2A5A5, 8'h00, r);
    chk(r == 8'hC3, "R3", "read after overwrite", r, 8'hC3);
    access(0, 19'h00010, 8'h00, r);
    chk(r == pat(19'h00010), "R3", "read after read", r, pat(19'h00010));

    // retention: request and access arrive together (R10)
    while (!req_ready) tick();
    ret_req = 1; req_valid = 1; req_write = 0; req_addr = 19'h4;
    k = 0;
    do begin
      tick(); k++;
      chk(sram_cs_n && !req_ready, "R9", "deselected while entering", {sram_cs_n, req_ready}, 2'b10);
    end while (!ret_ready && k < 50);
    chk(k == E_DESEL + 1, "R9", "ret_ready delay", k, E_DESEL + 1);
    repeat (6) begin
      tick();
      chk(sram_cs_n && ret_ready && !rsp_ack, "R10", "no access in retention", {sram_cs_n, ret_ready, rsp_ack}, 3'b110);
    end
    ret_req = 0; req_valid = 0;
    tick();
    chk(!ret_ready, "R11", "ret_ready falls", ret_ready, 0);
    k = 1;
    while (!req_ready && k < 50) begin
      chk(sram_cs_n, "R11", "deselected in recovery", sram_cs_n, 1);
      tick(); k++;
    end
    chk(k == E_RECOV + 1, "R11", "recovery length", k, E_RECOV + 1);
    access(0, 19'h00004, 8'h00, r);
    chk(r == pat(19'h00004), "R11", "first read after recovery", r, pat(19'h00004));

    chk(conflicts == 0, "R6", "bus contention cycles", conflicts, 0);
    chk(addr_errs == 0, "R8", "address changes in access", addr_errs, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) chk(0, "WD", "watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule